// File: doc/BRIEF.md
# Instrument status and service-request logic

This block keeps the status picture of a message-based instrument interface. Single-cycle event strobes from the command layer (command error, execution error, query error), a completion tracker for operation-complete requests and a one-shot power-up marker are collected into an 8-bit event status register. The register is sticky, and it is cleared by the very read that returns its contents. An 8-bit event enable mask reduces the register to one event-summary bit. A message-available bit follows the output queue's not-empty flag.

The event-summary and message-available bits form the status byte. They are combined with a service request enable register to drive a level interrupt. Software reaches the four registers through a small port with a select, a read strobe and a write strobe. Read data is combinational from the current state. A read of the event register clears it at the next clock edge.

Two small state machines drive the block. The completion tracker has two states. In `OPC_IDLE` the transition *arm* is taken when a request strobe arrives. In `OPC_WAIT` the transition *finish* is taken on the first edge at which no operation is busy: the operation-complete event is raised and the tracker returns to `OPC_IDLE`. The power-up sequencer has two states. It starts in `PWR_INIT` after reset and takes the transition *announce* to `PWR_RUN` on the first edge, raising the power-on event once. `PWR_RUN` then holds until the next reset.

Top module: `stat_srq_top`

## Requirements
- R1: The event status register (select 0) carries operation complete at bit 0, query error at bit 2, execution error at bit 4, command error at bit 5 and power-on at bit 7. Bits 1, 3 and 6 always read 0.
- R2: A read strobe with select 0 returns the register's current contents in the same cycle and clears every bit at the following clock edge.
- R3: Once a strobe sets an event bit, that bit stays set until the register is read with select 0. Reads and writes of other selects, and writes to select 0, leave it unchanged.
- R4: The operation-complete bit is set only after a request strobe: at the first clock edge after the request edge at which the busy input is low. It is never set while no request is pending.
- R5: The power-on bit is set at the first clock edge after reset is released, and only then.
- R6: The event enable register (select 1, read/write, all 8 bits) masks the event register. Status byte bit 5 is the OR of the masked bits.
- R7: Status byte bit 4 follows the queue-not-empty input in the same cycle.
- R8: The service request enable register (select 2) stores only bits 4 and 5. Its other bits read 0 whatever is written.
- R9: The interrupt output is high exactly when (status bit 4 and enable bit 4) or (status bit 5 and enable bit 5) holds. Status byte bit 6 (select 3, read-only, bits 0–3 and 7 zero) shows the same level.
- R10: An event strobe in the same cycle as a clearing read leaves its bit set after that edge.
- R11: During reset the event, event-enable and service-enable registers are 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opc_req | input | 1 | Operation-complete request strobe |
| ops_busy | input | 1 | High while any operation is pending |
| evt_qerr | input | 1 | Output data lost strobe |
| evt_exe | input | 1 | Execution error strobe |
| evt_cme | input | 1 | Command error strobe |
| q_nempty | input | 1 | Output queue holds a message |
| reg_sel | input | 2 | Register select: 0 event, 1 event enable, 2 service enable, 3 status byte |
| reg_rd | input | 1 | Read strobe (clears the event register when select is 0) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Service request level |

## Verification
A lost or stuck event bit shows at the next read of select 0, and in the same cycle on the interrupt if its enable path is open. Comparing the read data and the interrupt every cycle therefore exposes it within one access. A completion tracker left in the wrong state shows as an operation-complete bit that appears without a request, or one that is still missing one edge after busy falls. A power-up sequencer that fails to leave `PWR_INIT` shows as the power-on bit coming back after it has been cleared.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned SEL_W  = 2;

    localparam int unsigned EB_OPC  = 0;
    localparam int unsigned EB_QERR = 2;
    localparam int unsigned EB_EXE  = 4;
    localparam int unsigned EB_CME  = 5;
    localparam int unsigned EB_PON  = 7;

    localparam int unsigned SB_MAV = 4;
    localparam int unsigned SB_ESB = 5;
    localparam int unsigned SB_SRQ = 6;

    localparam logic [REG_W-1:0] EVT_USED = (REG_W'(1) << EB_OPC) | (REG_W'(1) << EB_QERR)
                                          | (REG_W'(1) << EB_EXE) | (REG_W'(1) << EB_CME)
                                          | (REG_W'(1) << EB_PON);
    localparam logic [REG_W-1:0] SEN_USED = (REG_W'(1) << SB_MAV) | (REG_W'(1) << SB_ESB);

    typedef enum logic [SEL_W-1:0] {
        RS_EVT = 2'd0,
        RS_EEN = 2'd1,
        RS_SEN = 2'd2,
        RS_STB = 2'd3
    } reg_sel_e;

    typedef enum logic {
        OPC_IDLE = 1'b0,
        OPC_WAIT = 1'b1
    } opc_state_e;

    typedef enum logic {
        PWR_INIT = 1'b0,
        PWR_RUN  = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/stat_pwr_fsm.sv
module stat_pwr_fsm
    import stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic pon_evt
);
    pwr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pon_evt = 1'b0;
        unique case (state_q)
            PWR_INIT: begin
                pon_evt = 1'b1;
                state_d = PWR_RUN;
            end
            PWR_RUN: begin
                pon_evt = 1'b0;
            end
            default: state_d = PWR_RUN;
        endcase
    end

    p_pon_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_RUN) |=> (state_q == PWR_RUN) && !pon_evt);
endmodule

// File: rtl/stat_opc_fsm.sv
module stat_opc_fsm
    import stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic opc_req,
    input  logic ops_busy,
    output logic opc_evt
);
    opc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OPC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        opc_evt = 1'b0;
        unique case (state_q)
            OPC_IDLE: begin
                if (opc_req) state_d = OPC_WAIT;
            end
            OPC_WAIT: begin
                if (!ops_busy) begin
                    opc_evt = 1'b1;
                    state_d = OPC_IDLE;
                end
            end
            default: state_d = OPC_IDLE;
        endcase
    end

    p_opc_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OPC_IDLE) |-> !opc_evt);
    p_opc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OPC_WAIT && ops_busy) |=> (state_q == OPC_WAIT));
endmodule

// File: rtl/stat_evt_reg.sv
module stat_evt_reg
    import stat_pkg::*;
#(
    parameter int unsigned       W    = REG_W,
    parameter logic [W-1:0]      USED = EVT_USED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_set,
    input  logic         clr,
    output logic [W-1:0] esr
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (USED[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= (bit_q & ~clr) | ev_set[i];
            end
            assign esr[i] = bit_q;
        end else begin : g_dead
            assign esr[i] = 1'b0;
        end
    end

    p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (esr & ~USED) == '0);
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((esr & $past(esr)) == $past(esr)));
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ev_set == '0) |=> (esr == '0));
    p_survive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((esr & $past(ev_set & USED)) == $past(ev_set & USED)));
endmodule

// File: rtl/stat_srq_sum.sv
module stat_srq_sum
    import stat_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic [W-1:0] esr,
    input  logic [W-1:0] ese,
    input  logic [W-1:0] sre,
    input  logic         mav,
    output logic [W-1:0] stb,
    output logic         irq
);
    logic esb;
    logic srq;

    always_comb begin
        esb = |(esr & ese);
        srq = (mav & sre[SB_MAV]) | (esb & sre[SB_ESB]);
        stb = '0;
        stb[SB_MAV] = mav;
        stb[SB_ESB] = esb;
        stb[SB_SRQ] = srq;
        irq = srq;
    end
endmodule

// File: rtl/stat_srq_top.sv
module stat_srq_top
    import stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opc_req,
    input  logic             ops_busy,
    input  logic             evt_qerr,
    input  logic             evt_exe,
    input  logic             evt_cme,
    input  logic             q_nempty,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    reg_sel_e        sel;
    logic            pon_evt;
    logic            opc_evt;
    logic            clr_evt;
    logic [REG_W-1:0] ev_set;
    logic [REG_W-1:0] esr;
    logic [REG_W-1:0] ese_q;
    logic [REG_W-1:0] sre_q;
    logic [REG_W-1:0] stb;

    assign sel     = reg_sel_e'(reg_sel);
    assign clr_evt = reg_rd && (sel == RS_EVT);

    always_comb begin
        ev_set          = '0;
        ev_set[EB_OPC]  = opc_evt;
        ev_set[EB_QERR] = evt_qerr;
        ev_set[EB_EXE]  = evt_exe;
        ev_set[EB_CME]  = evt_cme;
        ev_set[EB_PON]  = pon_evt;
    end

    stat_pwr_fsm u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pon_evt (pon_evt)
    );

    stat_opc_fsm u_opc (
        .clk      (clk),
        .rst_n    (rst_n),
        .opc_req  (opc_req),
        .ops_busy (ops_busy),
        .opc_evt  (opc_evt)
    );

    stat_evt_reg #(.W(REG_W), .USED(EVT_USED)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_set (ev_set),
        .clr    (clr_evt),
        .esr    (esr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ese_q <= '0;
            sre_q <= '0;
        end else if (reg_wr) begin
            if (sel == RS_EEN) ese_q <= reg_wdata;
            if (sel == RS_SEN) sre_q <= reg_wdata & SEN_USED;
        end
    end

    stat_srq_sum #(.W(REG_W)) u_sum (
        .esr (esr),
        .ese (ese_q),
        .sre (sre_q),
        .mav (q_nempty),
        .stb (stb),
        .irq (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            RS_EVT: reg_rdata = esr;
            RS_EEN: reg_rdata = ese_q;
            RS_SEN: reg_rdata = sre_q;
            RS_STB: reg_rdata = stb;
            default: reg_rdata = '0;
        endcase
    end

    p_sre_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sre_q & ~SEN_USED) == '0);
    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sre_q == '0) |-> !irq);
    p_mav_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == RS_STB) |-> (reg_rdata[SB_MAV] == q_nempty));
endmodule

// File: tb/test_stat_srq_top.sv
`timescale 1ns/100ps
module test_stat_srq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opc_req = 0, ops_busy = 0, evt_qerr = 0, evt_exe = 0, evt_cme = 0;
    logic       q_nempty = 0;
    logic [1:0] reg_sel = 0;
    logic       reg_rd = 0, reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_esr, m_ese, m_sre;
    bit         m_wait, m_pon;

    always #2 clk = ~clk;

    stat_srq_top i_stat_srq_top (
        .clk(clk), .rst_n(rst_n), .opc_req(opc_req), .ops_busy(ops_busy),
        .evt_qerr(evt_qerr), .evt_exe(evt_exe), .evt_cme(evt_cme),
        .q_nempty(q_nempty), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_irq();
        bit esb = |(m_esr & m_ese);
        return (q_nempty && m_sre[4]) || (esb && m_sre[5]);
    endfunction

    function automatic logic [7:0] m_rdata();
        case (reg_sel)
            2'd0: return m_esr;
            2'd1: return m_ese;
            2'd2: return m_sre;
            default: return {1'b0, m_irq(), |(m_esr & m_ese), q_nempty, 4'b0};
        endcase
    endfunction

    function automatic string sel_tag();
        case (reg_sel)
            2'd0: return "R2";
            2'd1: return "R6";
            2'd2: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic model_next();
        logic [7:0] ev;
        if (!rst_n) begin
            m_esr = 0; m_ese = 0; m_sre = 0; m_wait = 0; m_pon = 1;
            return;
        end
        ev = 0;
        ev[0] = m_wait && !ops_busy;
        ev[2] = evt_qerr;
        ev[4] = evt_exe;
        ev[5] = evt_cme;
        ev[7] = m_pon;
        m_pon = 0;
        if (m_wait) begin
            if (!ops_busy) m_wait = 0;
        end else if (opc_req) m_wait = 1;
        m_esr = ((reg_rd && reg_sel == 2'd0) ? 8'h00 : m_esr) | ev;
        if (reg_wr && reg_sel == 2'd1) m_ese = reg_wdata;
        if (reg_wr && reg_sel == 2'd2) m_sre = reg_wdata & 8'h30;
    endtask

    task automatic tick();
        #0.5;
        chk(sel_tag(), reg_rdata, m_rdata());
        chk("R9", {7'b0, irq}, {7'b0, m_irq()});
        model_next();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #0.2;
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_esr = 0; m_ese = 0; m_sre = 0; m_wait = 0; m_pon = 1;
        @(negedge clk);
        repeat (3) tick();
        settle();
        chk("R11", reg_rdata, 8'h00);
        chk("R11", {7'b0, irq}, 8'h00);
        reg_sel = 2'd2; settle(); chk("R11", reg_rdata, 8'h00);
        reg_sel = 2'd0;
        rst_n = 1'b1;
        tick();
        reg_rd = 1; settle();
        chk("R5", reg_rdata, 8'h80);
        chk("R1", reg_rdata & 8'h4A, 8'h00);
        tick();
        reg_rd = 0; settle();
        chk("R2", reg_rdata, 8'h00);
        tick();
        // sticky events
        evt_exe = 1; tick(); evt_exe = 0;
        evt_cme = 1; tick(); evt_cme = 0;
        reg_sel = 2'd1; reg_rd = 1; tick(); reg_rd = 0;
        reg_sel = 2'd0; reg_wr = 1; reg_wdata = 8'hFF; tick(); reg_wr = 0;
        repeat (2) tick();
        settle(); chk("R3", reg_rdata, 8'h30);
        evt_qerr = 1; tick(); evt_qerr = 0;
        settle(); chk("R3", reg_rdata, 8'h34);
        chk("R1", reg_rdata & 8'h4A, 8'h00);
        // event enable
        reg_sel = 2'd1; reg_wr = 1; reg_wdata = 8'h10; tick(); reg_wr = 0;
        reg_sel = 2'd3; settle();
        chk("R6", reg_rdata & 8'h20, 8'h20);
        chk("R9", {7'b0, irq}, 8'h00);
        // service enable = 32
        reg_sel = 2'd2; reg_wr = 1; reg_wdata = 8'd32; tick(); reg_wr = 0;
        reg_sel = 2'd3; settle();
        chk("R9", {7'b0, irq}, 8'h01);
        chk("R9", reg_rdata, 8'h60);
        reg_sel = 2'd2; reg_wr = 1; reg_wdata = 8'hFF; tick(); reg_wr = 0;
        settle(); chk("R8", reg_rdata, 8'h30);
        // only message-available source
        reg_wr = 1; reg_wdata = 8'h10; tick(); reg_wr = 0;
        reg_sel = 2'd3; settle();
        chk("R9", {7'b0, irq}, 8'h00);
        q_nempty = 1; settle();
        chk("R7", reg_rdata & 8'h10, 8'h10);
        chk("R9", {7'b0, irq}, 8'h01);
        tick();
        q_nempty = 0; settle();
        chk("R7", reg_rdata & 8'h10, 8'h00);
        // clear with simultaneous strobe
        reg_sel = 2'd0; reg_rd = 1; evt_cme = 1; tick(); reg_rd = 0; evt_cme = 0;
        settle(); chk("R10", reg_rdata, 8'h20);
        reg_rd = 1; tick(); reg_rd = 0;
        // operation complete
        repeat (3) tick();
        settle(); chk("R4", reg_rdata & 8'h01, 8'h00);
        opc_req = 1; ops_busy = 1; tick(); opc_req = 0;
        repeat (3) tick();
        settle(); chk("R4", reg_rdata & 8'h01, 8'h00);
        ops_busy = 0; tick();
        settle(); chk("R4", reg_rdata & 8'h01, 8'h01);
        reg_rd = 1; tick(); reg_rd = 0;
        repeat (4) tick();
        settle(); chk("R4", reg_rdata & 8'h01, 8'h00);
        chk("R5", reg_rdata & 8'h80, 8'h00);
        // random traffic compared every clock
        for (int n = 0; n < 3000; n++) begin
            opc_req   = ($urandom_range(15) == 0);
            ops_busy  = ($urandom_range(3) != 0);
            evt_qerr  = ($urandom_range(15) == 0);
            evt_exe   = ($urandom_range(15) == 0);
            evt_cme   = ($urandom_range(15) == 0);
            q_nempty  = $urandom_range(1);
            reg_sel   = 2'($urandom_range(3));
            reg_rd    = ($urandom_range(3) == 0);
            reg_wr    = ($urandom_range(7) == 0);
            reg_wdata = 8'($urandom_range(255));
            tick();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule